// File: doc/BRIEF.md
# Reference-Interval Clock Frequency Meter

The block finds the rate of its own fast clock by timing a fixed interval of a slower reference clock. A 64-bit cycle counter runs freely on the fast clock. A small one-shot down-counter, advanced once per reference tick, stands in for the timing channel. A sequencer programs that counter through a command/data byte path and starts and stops it through an internal control register. The control register carries a run-enable bit, a sound-enable bit and a read-only copy of the counter's terminal-count output.

A measurement starts on a pulse on `start`. The sequencer first clears the run-enable and sound-enable bits, then writes the command byte and the 16-bit reload value (low byte, then high byte). Next it sets run-enable and records the cycle counter in the same cycle. It then polls the terminal-count status bit. On the first cycle that bit reads as set, it takes the elapsed cycle count. An iterative divider divides that count by the scale factor. An iterative binary-to-BCD converter then turns the quotient into packed decimal digits. Only after both finish does `done` rise.

With the default reload of 11931 reference ticks at 1,193,182 Hz, the interval is 10 ms, and dividing by 10,000 yields MHz. If terminal count is not seen within a programmable number of poll cycles, the run ends with an error flag instead of a result.

Top module: `freq_meter`

## Requirements
- R1: After reset, `busy`, `done`, `timeout_err`, `tmr_out` and `speaker` are 0 and `mhz_bcd` is all zeros.
- R2: A `start` pulse sampled while idle makes `busy` read 1 and `done` read 0 on the next cycle.
- R3: The sequencer runs its steps in a fixed order: it clears control bits 0 (run-enable) and 1 (sound-enable), writes command byte 8'b1011_0000 (channel 2 in bits 7:6, low-then-high byte access in bits 5:4, one-shot mode 000 in bits 3:1, binary in bit 0), writes the reload low byte, writes the reload high byte, then sets bit 0.
- R4: `elapsed` equals the cycle count at the first poll that sees status bit 5 set, minus the count in the cycle bit 0 was set. With a reference tick every P cycles, it lies in [(RELOAD-1)*P+2, RELOAD*P+1].
- R5: Writing the command byte drives `tmr_out` low. It rises only after RELOAD counted ticks while run-enable is 1, and it stays high until the next command.
- R6: `mhz_bcd` holds floor(elapsed/SCALE) as packed BCD, least significant digit in bits 3:0, four bits per digit.
- R7: A quotient above 10^NDIG-1 is shown as all nines.
- R8: `done` rises only after both the division and the conversion have completed, and it holds with `busy` low until the next start.
- R9: If status bit 5 is not seen within `timeout_limit` poll cycles, the run ends with `timeout_err`=1, `done`=0 and `mhz_bcd` zero.
- R10: `speaker` is the AND of the counter output and control bit 1; because a run clears bit 1, `speaker` stays 0.
- R11: A `start` pulse while `busy` is ignored: no second measurement follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock being measured |
| rst_n | input | 1 | Active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| start | input | 1 | Begins a measurement when idle |
| timeout_limit | input | 32 | Poll cycles allowed before error |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Result valid |
| timeout_err | output | 1 | Terminal count not seen in time |
| elapsed | output | CW | Fast cycles in the interval |
| mhz_bcd | output | 4*NDIG | Frequency in packed BCD |
| tmr_out | output | 1 | Timer terminal-count output |
| speaker | output | 1 | Counter output gated by sound-enable |

## Verification
The embedded assertions check these properties on every cycle:
- the run-enable set step is reached only from the high-byte write;
- no state other than idle ever leads back into the stop step;
- `done` follows a conversion finish and excludes both `busy` and the error flag;
- the divider remainder stays below the divisor;
- every result digit is at most nine;
- the counter output rises only while run-enable is set;
- `speaker` is quiet during a run.

The bench's scenarios are needed for the parts assertions cannot show:
- the numerical value of `elapsed` against the tick spacing;
- the exact decimal result, including carries and saturation;
- the timeout path with and without ticks;
- the clearing of the counter output by a fresh command.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_STOP, S_CMD, S_LO, S_HI, S_GO, S_POLL, S_DIV, S_BCD
  } seq_state_t;

  localparam logic [7:0] CMD_CH2_ONESHOT = 8'b1011_0000;
  localparam logic [7:0] CTL_RUN_MASK    = 8'h01;
  localparam logic [7:0] CTL_SND_MASK    = 8'h02;
  localparam logic [7:0] CTL_RW_MASK     = 8'h0F;
  localparam logic [7:0] CTL_OUT_MASK    = 8'h20;
  localparam int         TMR_W           = 16;
endpackage

// File: rtl/fm_ctrl_reg.sv
module fm_ctrl_reg
  import fm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_val,
  input  logic       tmr_out,
  output logic [7:0] rd_val,
  output logic       run_en,
  output logic       speaker
);
  logic [7:0] rw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rw_q <= '0;
    else if (wr_en) rw_q <= wr_val & CTL_RW_MASK;
  end

  assign rd_val  = rw_q | (tmr_out ? CTL_OUT_MASK : 8'h00);
  assign run_en  = rw_q[0];
  assign speaker = tmr_out & rw_q[1];
endmodule

// File: rtl/fm_oneshot_timer.sv
module fm_oneshot_timer
  import fm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run_en,
  input  logic       cmd_we,
  input  logic       data_we,
  input  logic [7:0] wdata,
  output logic       out_q
);
  logic [1:0]       acc_q;
  logic [2:0]       mode_q;
  logic             dec_q;
  logic             hi_next_q;
  logic [7:0]       lo_q;
  logic [TMR_W-1:0] cnt_q;
  logic             loaded_q;

  wire cmd_hit  = cmd_we && (wdata[7:6] == 2'b10);
  wire counting = loaded_q && run_en && tick && !out_q &&
                  (mode_q == 3'b000) && !dec_q;
  wire tc_hit   = counting && (cnt_q == TMR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; mode_q <= '0; dec_q <= 1'b0; hi_next_q <= 1'b0;
      lo_q <= '0; cnt_q <= '0; loaded_q <= 1'b0; out_q <= 1'b0;
    end else if (cmd_hit) begin
      acc_q     <= wdata[5:4];
      mode_q    <= wdata[3:1];
      dec_q     <= wdata[0];
      hi_next_q <= 1'b0;
      loaded_q  <= 1'b0;
      out_q     <= 1'b0;
    end else if (data_we) begin
      out_q <= 1'b0;
      case (acc_q)
        2'b01: begin cnt_q <= {8'h00, wdata}; loaded_q <= 1'b1; end
        2'b10: begin cnt_q <= {wdata, 8'h00}; loaded_q <= 1'b1; end
        2'b11: begin
          if (!hi_next_q) begin
            lo_q <= wdata; hi_next_q <= 1'b1; loaded_q <= 1'b0;
          end else begin
            cnt_q <= {wdata, lo_q}; hi_next_q <= 1'b0; loaded_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end else if (counting) begin
      cnt_q <= cnt_q - TMR_W'(1);
      if (tc_hit) out_q <= 1'b1;
    end
  end

  assert_out_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(run_en));
endmodule

// File: rtl/fm_divider.sv
module fm_divider #(
  parameter int W       = 64,
  parameter int DIVISOR = 10000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int         ITW = $clog2(W + 1);
  localparam logic [W:0] DV  = (W+1)'(DIVISOR);

  logic [W:0]     rem_q;
  logic [W-1:0]   q_q;
  logic [ITW-1:0] it_q;
  logic           run_q;
  logic           done_q;

  function automatic logic [2*W:0] div_step(logic [W:0] r, logic [W-1:0] q);
    logic [W:0]   rs;
    logic [W-1:0] qs;
    rs = {r[W-1:0], q[W-1]};
    qs = {q[W-2:0], 1'b0};
    if (rs >= DV) begin
      rs    = rs - DV;
      qs[0] = 1'b1;
    end
    return {rs, qs};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; q_q <= '0; it_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        q_q   <= dividend;
        it_q  <= ITW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        {rem_q, q_q} <= div_step(rem_q, q_q);
        it_q <= it_q - ITW'(1);
        if (it_q == ITW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quotient = q_q;
  assign done     = done_q;

  assert_rem_below_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rem_q < DV));
endmodule

// File: rtl/fm_bcd_conv.sv
module fm_bcd_conv #(
  parameter int BW   = 20,
  parameter int NDIG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BW-1:0]     bin,
  output logic [4*NDIG-1:0] digits,
  output logic              done
);
  localparam int DW  = 4 * NDIG;
  localparam int ITW = $clog2(BW + 1);

  logic [DW-1:0]  bcd_q;
  logic [BW-1:0]  v_q;
  logic [ITW-1:0] it_q;
  logic           run_q;
  logic           done_q;

  function automatic logic [DW+BW-1:0] dd_step(logic [DW-1:0] b, logic [BW-1:0] v);
    logic [DW-1:0] t;
    t = b;
    for (int i = 0; i < NDIG; i++)
      if (t[4*i +: 4] >= 4'd5) t[4*i +: 4] = t[4*i +: 4] + 4'd3;
    return {t, v} << 1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcd_q <= '0; v_q <= '0; it_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        bcd_q <= '0;
        v_q   <= bin;
        it_q  <= ITW'(BW);
        run_q <= 1'b1;
      end else if (run_q) begin
        {bcd_q, v_q} <= dd_step(bcd_q, v_q);
        it_q <= it_q - ITW'(1);
        if (it_q == ITW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign digits = bcd_q;
  assign done   = done_q;

  for (genvar d = 0; d < NDIG; d++) begin : g_digit_chk
    assert_digit_decimal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (bcd_q[4*d +: 4] <= 4'd9));
  end
endmodule

// File: rtl/fm_seq.sv
module fm_seq
  import fm_pkg::*;
#(
  parameter int CW     = 64,
  parameter int NDIG   = 6,
  parameter int BW     = 20,
  parameter int MAXV   = 999999,
  parameter int RELOAD = 11931
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       timeout_limit,
  input  logic [CW-1:0]     cyc,
  input  logic [7:0]        ctrl_rd,
  output logic              ctrl_we,
  output logic [7:0]        ctrl_wval,
  output logic              tmr_cmd_we,
  output logic              tmr_data_we,
  output logic [7:0]        tmr_wdata,
  output logic              div_start,
  output logic [CW-1:0]     div_dividend,
  input  logic [CW-1:0]     div_quot,
  input  logic              div_done,
  output logic              bcd_start,
  output logic [BW-1:0]     bcd_bin,
  input  logic [4*NDIG-1:0] bcd_digits,
  input  logic              bcd_done,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic [CW-1:0]     elapsed,
  output logic [4*NDIG-1:0] mhz_bcd
);
  localparam logic [TMR_W-1:0] RLD = TMR_W'(RELOAD);

  seq_state_t        state_q;
  logic [CW-1:0]     t0_q;
  logic [CW-1:0]     elapsed_q;
  logic [31:0]       tmo_q;
  logic              done_q;
  logic              err_q;
  logic [4*NDIG-1:0] mhz_q;

  function automatic logic [CW-1:0] span(logic [CW-1:0] now, logic [CW-1:0] then_);
    return now - then_;
  endfunction

  function automatic logic [BW-1:0] clamp_q(logic [CW-1:0] q);
    if (q > CW'(MAXV)) return BW'(MAXV);
    return q[BW-1:0];
  endfunction

  wire status_out = (ctrl_rd & CTL_OUT_MASK) != 8'h00;
  wire out_seen   = (state_q == S_POLL) && status_out;
  wire tmo_hit    = (state_q == S_POLL) && !status_out && (tmo_q >= timeout_limit);
  wire start_ok   = (state_q == S_IDLE) && start;

  always_comb begin
    ctrl_we     = (state_q == S_STOP) || (state_q == S_GO);
    ctrl_wval   = (state_q == S_GO) ? (ctrl_rd | CTL_RUN_MASK)
                                    : (ctrl_rd & ~(CTL_RUN_MASK | CTL_SND_MASK));
    tmr_cmd_we  = (state_q == S_CMD);
    tmr_data_we = (state_q == S_LO) || (state_q == S_HI);
    case (state_q)
      S_CMD:   tmr_wdata = CMD_CH2_ONESHOT;
      S_LO:    tmr_wdata = RLD[7:0];
      S_HI:    tmr_wdata = RLD[15:8];
      default: tmr_wdata = 8'h00;
    endcase
  end

  assign div_start    = out_seen;
  assign div_dividend = span(cyc, t0_q);
  assign bcd_start    = (state_q == S_DIV) && div_done;
  assign bcd_bin      = clamp_q(div_quot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; t0_q <= '0; elapsed_q <= '0; tmo_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; mhz_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_ok) begin
          done_q <= 1'b0; err_q <= 1'b0; mhz_q <= '0; elapsed_q <= '0;
          state_q <= S_STOP;
        end
        S_STOP: state_q <= S_CMD;
        S_CMD:  state_q <= S_LO;
        S_LO:   state_q <= S_HI;
        S_HI:   state_q <= S_GO;
        S_GO: begin
          t0_q    <= cyc;
          tmo_q   <= '0;
          state_q <= S_POLL;
        end
        S_POLL: begin
          if (out_seen) begin
            elapsed_q <= span(cyc, t0_q);
            state_q   <= S_DIV;
          end else if (tmo_hit) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            tmo_q <= tmo_q + 32'd1;
          end
        end
        S_DIV: if (div_done) state_q <= S_BCD;
        S_BCD: if (bcd_done) begin
          mhz_q   <= bcd_digits;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;
  assign elapsed     = elapsed_q;
  assign mhz_bcd     = mhz_q;

  assert_run_after_high_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_GO) |-> ($past(state_q) == S_HI));
  assert_done_after_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(bcd_done));
  assert_done_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == S_IDLE));
  assert_err_excludes_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !done_q);
  assert_no_restart_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> (state_q != S_STOP));
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int CW     = 64,
  parameter int RELOAD = 11931,
  parameter int SCALE  = 10000,
  parameter int NDIG   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              start,
  input  logic [31:0]       timeout_limit,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic [CW-1:0]     elapsed,
  output logic [4*NDIG-1:0] mhz_bcd,
  output logic              tmr_out,
  output logic              speaker
);
  localparam int MAXV = 10**NDIG - 1;
  localparam int BW   = $clog2(MAXV + 1);

  logic [CW-1:0]     cyc_q;
  logic [7:0]        ctrl_rd, ctrl_wval;
  logic              ctrl_we, run_en;
  logic              tmr_cmd_we, tmr_data_we;
  logic [7:0]        tmr_wdata;
  logic              div_start, div_done;
  logic [CW-1:0]     div_dividend, div_quot;
  logic              bcd_start, bcd_done;
  logic [BW-1:0]     bcd_bin;
  logic [4*NDIG-1:0] bcd_digits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_q + CW'(1);
  end

  fm_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_we), .wr_val(ctrl_wval),
    .tmr_out(tmr_out), .rd_val(ctrl_rd), .run_en(run_en), .speaker(speaker)
  );

  fm_oneshot_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .run_en(run_en),
    .cmd_we(tmr_cmd_we), .data_we(tmr_data_we), .wdata(tmr_wdata), .out_q(tmr_out)
  );

  fm_divider #(.W(CW), .DIVISOR(SCALE)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(div_dividend),
    .quotient(div_quot), .done(div_done)
  );

  fm_bcd_conv #(.BW(BW), .NDIG(NDIG)) u_bcd (
    .clk(clk), .rst_n(rst_n), .start(bcd_start), .bin(bcd_bin),
    .digits(bcd_digits), .done(bcd_done)
  );

  fm_seq #(.CW(CW), .NDIG(NDIG), .BW(BW), .MAXV(MAXV), .RELOAD(RELOAD)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .timeout_limit(timeout_limit),
    .cyc(cyc_q), .ctrl_rd(ctrl_rd), .ctrl_we(ctrl_we), .ctrl_wval(ctrl_wval),
    .tmr_cmd_we(tmr_cmd_we), .tmr_data_we(tmr_data_we), .tmr_wdata(tmr_wdata),
    .div_start(div_start), .div_dividend(div_dividend), .div_quot(div_quot),
    .div_done(div_done), .bcd_start(bcd_start), .bcd_bin(bcd_bin),
    .bcd_digits(bcd_digits), .bcd_done(bcd_done), .busy(busy), .done(done),
    .timeout_err(timeout_err), .elapsed(elapsed), .mhz_bcd(mhz_bcd)
  );

  assert_speaker_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !speaker);
endmodule

// File: tb/test_freq_meter.sv
`timescale 1ns/1ps
module test_freq_meter;
  localparam int CW   = 64;
  localparam int RLD  = 20;
  localparam int SCL  = 10;
  localparam int ND   = 3;
  localparam int MAXV = 999;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_tick = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       timeout_limit = 32'd100000;
  logic              busy, done, timeout_err, tmr_out, speaker;
  logic [CW-1:0]     elapsed;
  logic [4*ND-1:0]   mhz_bcd;

  int total = 0;
  int bad = 0;
  int tick_per = 0;
  bit spk_seen = 1'b0;
  bit finished = 1'b0;

  freq_meter #(.CW(CW), .RELOAD(RLD), .SCALE(SCL), .NDIG(ND)) i_freq_meter (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .start(start),
    .timeout_limit(timeout_limit), .busy(busy), .done(done),
    .timeout_err(timeout_err), .elapsed(elapsed), .mhz_bcd(mhz_bcd),
    .tmr_out(tmr_out), .speaker(speaker)
  );

  initial forever #4 clk = ~clk;

  initial begin : tick_gen
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (tick_per == 0) begin
        ref_tick = 1'b0; cnt = 0;
      end else begin
        ref_tick = (cnt >= tick_per - 1);
        cnt = (cnt >= tick_per - 1) ? 0 : cnt + 1;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && speaker) spk_seen = 1'b1;
  end

  function automatic logic [4*ND-1:0] exp_digits(longint unsigned e);
    longint unsigned q;
    logic [4*ND-1:0] r;
    q = e / SCL;
    if (q > MAXV) q = MAXV;
    r = '0;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = 4'(q % 10);
      q = q / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run_meas(input int per, input int lim, input bit expect_tmo,
                          input bit poke_start);
    int waited;
    longint unsigned lo, hi, e;
    tick_per = per;
    timeout_limit = 32'(lim);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    check(done == 1'b0, "R2", "done cleared", done, 0);
    @(negedge clk);
    if (poke_start) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(tmr_out == 1'b0, "R5", "out low after command", tmr_out, 0);
    waited = 0;
    while (busy && waited < 60000) begin
      @(negedge clk);
      waited++;
    end
    check(!busy, "R8", "run finished", busy, 0);
    e = elapsed;
    if (expect_tmo) begin
      check(timeout_err == 1'b1, "R9", "timeout flag", timeout_err, 1);
      check(done == 1'b0, "R9", "no done on timeout", done, 0);
      check(mhz_bcd == '0, "R9", "result zero on timeout", mhz_bcd, 0);
    end else begin
      lo = longint'(RLD - 1) * per + 2;
      hi = longint'(RLD) * per + 1;
      check(done == 1'b1, "R8", "done raised", done, 1);
      check(timeout_err == 1'b0, "R9", "no timeout", timeout_err, 0);
      check(e >= lo && e <= hi, "R4", "elapsed window low", e, lo);
      check(mhz_bcd == exp_digits(e), "R6", "bcd result", mhz_bcd, exp_digits(e));
      check(tmr_out == 1'b1, "R5", "out high after count", tmr_out, 1);
      repeat (12) @(negedge clk);
      check(!busy && done, "R11", "no second run, done held", {busy, done}, 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check(!busy && !done && !timeout_err, "R1", "flags at reset",
          {busy, done, timeout_err}, 0);
    check(mhz_bcd == '0 && !tmr_out && !speaker, "R1", "outputs at reset",
          {mhz_bcd, tmr_out, speaker}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 exact case: one tick per cycle gives RELOAD+1 cycles
    run_meas(1, 100000, 1'b0, 1'b0);
    check(elapsed == 64'(RLD + 1), "R4", "elapsed exact at tick every cycle",
          elapsed, RLD + 1);
    check(mhz_bcd == 12'h002, "R6", "two MHz digits", mhz_bcd, 12'h002);

    // R11: start pulsed mid-run
    run_meas(7, 100000, 1'b0, 1'b1);

    for (int k = 0; k < 8; k++) run_meas(int'($urandom_range(2, 40)), 100000, 1'b0, 1'b0);

    // R6 carry region near 100
    run_meas(50, 100000, 1'b0, 1'b0);

    // R7 saturation
    run_meas(600, 100000, 1'b0, 1'b0);
    check(mhz_bcd == 12'h999, "R7", "saturated nines", mhz_bcd, 12'h999);

    // R9 no ticks, and ticks too slow
    run_meas(0, 50, 1'b1, 1'b0);
    run_meas(40, 100, 1'b1, 1'b0);

    // recovery after timeout
    run_meas(3, 100000, 1'b0, 1'b0);

    check(!spk_seen, "R10", "speaker stayed quiet", spk_seen, 0);
    finish_up();
  end
endmodule